// File: doc/BRIEF.md
# Miss Stream Tracker with Direction Training

This block watches the line addresses of cache misses and turns regular miss streams into prefetch requests. It keeps a small table of stream entries. A miss that no entry claims takes over the least recently used entry and becomes that entry's anchor. The next two misses that land close to the anchor show whether the stream runs toward higher or lower addresses. When both of them point the same way, the entry switches to monitoring.

A monitoring entry guards a window of line addresses that sits just behind the stream's leading edge. A miss that falls inside the window causes a short burst of prefetches for the lines just past the leading edge, issued one per cycle. The window then slides forward by the number of lines prefetched. A level input chooses how large the window is and how many lines each hit prefetches. A feedback controller outside this block is expected to drive that input. While a burst is being issued, the block holds its miss input not-ready.

Top module: `sst_stream_tracker`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `pf_valid` is 0 and `miss_ready` is 1.
- R2: A miss that matches no entry is stored in the least recently used entry as a new anchor, and no prefetch is issued for it.
- R3: A training entry accepts a miss whose signed distance from its anchor is between -16 and +16 lines inclusive. A miss at distance 17 or more is not counted by that entry.
- R4: The first training miss sets the direction: ascending if its line is above the anchor, descending if below. If the second training miss lies on the same side, the entry starts monitoring. If it lies on the other side, it becomes the new anchor and training starts again. A training miss equal to the anchor changes nothing.
- R5: When training completes on line L with window size W, the window runs from L (start) to L+W-1 (end) for an ascending stream. A miss inside the window, both ends included, issues prefetches for end+1, end+2, and so on, one line per cycle on consecutive cycles, starting the cycle after the miss is accepted.
- R6: After a window hit with degree D and window size W, the end moves by D in the stream direction and the start is placed W-1 lines behind the new end. Any later miss is then tested against the new bounds.
- R7: The level input selects window/degree pairs as follows: 0 gives 4/1, 1 gives 8/1, 2 gives 16/2, 3 gives 32/4, 4 gives 64/4. Any value above 4 acts as 4. The level is sampled in the cycle a miss is accepted.
- R8: A descending stream mirrors the ascending case. Its window runs from L down to L-W+1, its prefetches go to end-1, end-2 and so on, and its bounds move downward.
- R9: There are 8 entries. A new allocation replaces the entry whose last allocation or match is the oldest, so a stream that has been idle through 8 newer allocations is lost.
- R10: A window hit issues exactly D prefetches. `miss_ready` is 0 whenever `pf_valid` is 1, and no miss is accepted until the burst has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A miss line address is presented |
| miss_line | input | LINE_W | Line address of the miss |
| aggr_level | input | LVL_W | Aggressiveness level, 0 to 4 |
| miss_ready | output | 1 | A miss can be accepted this cycle |
| pf_valid | output | 1 | A prefetch line address is presented |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
Some behaviours are checked by assertions on every cycle: a burst never runs longer than the largest degree, consecutive prefetch lines differ by exactly one, the input is held off while a burst is out, the selected degree is always one of the legal values, and the outputs are quiet under reset. Other behaviours can only be shown by the bench's scenarios, because they depend on the history of a stream. These are the training outcome (inclusive ±16 reach, agreement, restart after disagreement), the exact prefetch lines and how the window slides under each level, the clamping of out-of-range levels, the mirrored descending case, and the eviction of an idle stream after eight newer allocations.

// File: rtl/sst_pkg.sv
// Shared types and level decoding for the miss stream tracker.
// Assumes level values above the top level are clamped by the caller's use of level_clamp.
package sst_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_TRAIN0 = 2'd1,
        ST_TRAIN1 = 2'd2,
        ST_MON    = 2'd3
    } sst_state_e;

    localparam int TOP_LEVEL = 4;

    // Degree per level: 1,1,2,4,4
    function automatic int unsigned degree_of(input int unsigned lvl);
        if (lvl < 2)       return 1;
        else if (lvl == 2) return 2;
        else               return 4;
    endfunction

endpackage

// File: rtl/sst_level_map.sv
// Maps the aggressiveness level to window size and prefetch degree.
// Assumes window doubles per level from 4 lines; out-of-range levels act as the top level.
module sst_level_map #(
    parameter int LVL_W = 3,
    parameter int WIN_W = 7,
    parameter int DEG_W = 3
) (
    input  logic [LVL_W-1:0] level,
    output logic [WIN_W-1:0] win_size,
    output logic [DEG_W-1:0] degree
);
    import sst_pkg::*;

    localparam int BASE_LOG2 = 2;

    logic [LVL_W-1:0] lvl_c;

    // Clamp level and derive both table values
    always_comb begin
        lvl_c    = (int'(level) > TOP_LEVEL) ? LVL_W'(TOP_LEVEL) : level;
        win_size = WIN_W'(1) << (BASE_LOG2 + int'(lvl_c));
        degree   = DEG_W'(degree_of(int'(lvl_c)));
    end
endmodule

// File: rtl/sst_entry.sv
// One stream entry: anchor/training state, direction and monitor window.
// Assumes upd and alloc are never high together; line arithmetic wraps modulo 2**LINE_W.
module sst_entry #(
    parameter int LINE_W      = 32,
    parameter int WIN_W       = 7,
    parameter int DEG_W       = 3,
    parameter int TRAIN_RANGE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [WIN_W-1:0]  win_size,
    input  logic [DEG_W-1:0]  degree,
    input  logic              upd,
    input  logic              alloc,
    output logic              hit,
    output logic              mon_hit,
    output logic [LINE_W-1:0] pf_first,
    output logic              pf_up
);
    import sst_pkg::*;

    sst_state_e        st;
    logic [LINE_W-1:0] anchor, win_lo, win_hi;
    logic              up;

    logic [LINE_W-1:0] diff, absd, win_m1, deg_l, new_hi;
    logic              above;

    // Distance from anchor and window arithmetic
    always_comb begin
        diff   = miss_line - anchor;
        above  = ~diff[LINE_W-1];
        absd   = diff[LINE_W-1] ? (~diff + LINE_W'(1)) : diff;
        win_m1 = LINE_W'(win_size) - LINE_W'(1);
        deg_l  = LINE_W'(degree);
        new_hi = up ? (win_hi + deg_l) : (win_hi - deg_l);
    end

    // Match decision for the presented miss
    always_comb begin
        hit     = 1'b0;
        mon_hit = 1'b0;
        case (st)
            ST_TRAIN0, ST_TRAIN1: hit = (absd <= LINE_W'(TRAIN_RANGE));
            ST_MON: begin
                if (up) mon_hit = ((miss_line - win_lo) <= (win_hi - win_lo));
                else    mon_hit = ((win_lo - miss_line) <= (win_lo - win_hi));
                hit = mon_hit;
            end
            default: hit = 1'b0;
        endcase
    end

    assign pf_first = up ? (win_hi + LINE_W'(1)) : (win_hi - LINE_W'(1));
    assign pf_up    = up;

    // State update on allocation or match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_EMPTY;
            anchor <= '0;
            win_lo <= '0;
            win_hi <= '0;
            up     <= 1'b1;
        end else if (alloc) begin
            st     <= ST_TRAIN0;
            anchor <= miss_line;
        end else if (upd) begin
            case (st)
                ST_TRAIN0: begin
                    if (diff != '0) begin
                        up <= above;
                        st <= ST_TRAIN1;
                    end
                end
                ST_TRAIN1: begin
                    if (diff != '0) begin
                        if (above == up) begin
                            st     <= ST_MON;
                            win_lo <= miss_line;
                            win_hi <= up ? (miss_line + win_m1) : (miss_line - win_m1);
                        end else begin
                            st     <= ST_TRAIN0;
                            anchor <= miss_line;
                        end
                    end
                end
                ST_MON: begin
                    win_hi <= new_hi;
                    win_lo <= up ? (new_hi - win_m1) : (new_hi + win_m1);
                end
                default: st <= st;
            endcase
        end
    end
endmodule

// File: rtl/sst_lru.sv
// Age-ordered replacement for NUM entries; age NUM-1 is the victim.
// Assumes NUM is a power of two so ages form a permutation of 0..NUM-1.
module sst_lru #(
    parameter int NUM   = 8,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] age [NUM];

    // Move the touched entry to youngest, age the younger ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < NUM; i++) begin
                if (IDX_W'(i) == touch_idx)      age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + IDX_W'(1);
            end
        end
    end

    // Pick the oldest entry
    always_comb begin
        victim = '0;
        for (int i = 0; i < NUM; i++)
            if (age[i] == IDX_W'(NUM - 1)) victim = IDX_W'(i);
    end
endmodule

// File: rtl/sst_pf_issuer.sv
// Emits a burst of consecutive prefetch lines, one per cycle.
// Assumes load is only raised while no burst is pending.
module sst_pf_issuer #(
    parameter int LINE_W = 32,
    parameter int DEG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] load_line,
    input  logic              load_up,
    input  logic [DEG_W-1:0]  load_cnt,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              busy
);
    logic [DEG_W-1:0]  remain;
    logic [LINE_W-1:0] cur;
    logic              up;

    // Burst counter and line stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            cur    <= '0;
            up     <= 1'b1;
        end else if (load) begin
            remain <= load_cnt;
            cur    <= load_line;
            up     <= load_up;
        end else if (remain != '0) begin
            remain <= remain - DEG_W'(1);
            cur    <= up ? (cur + LINE_W'(1)) : (cur - LINE_W'(1));
        end
    end

    assign pf_valid = (remain != '0);
    assign pf_line  = cur;
    assign busy     = pf_valid;
endmodule

// File: rtl/sst_stream_tracker.sv
// Top: table of direction-training stream entries feeding a prefetch burst issuer.
// Assumes at most one miss per cycle; the lowest-index matching entry wins.
module sst_stream_tracker #(
    parameter int LINE_W      = 32,
    parameter int LVL_W       = 3,
    parameter int NUM         = 8,
    parameter int TRAIN_RANGE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [LVL_W-1:0]  aggr_level,
    output logic              miss_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);
    localparam int IDX_W = $clog2(NUM);
    localparam int WIN_W = 7;
    localparam int DEG_W = 3;

    logic [WIN_W-1:0]  cur_win;
    logic [DEG_W-1:0]  cur_degree;
    logic [NUM-1:0]    hit_v, mon_v, upd_v, alloc_v, up_v;
    logic [LINE_W-1:0] first_v [NUM];
    logic [IDX_W-1:0]  sel, victim;
    logic              any_hit, accept, busy;

    sst_level_map #(.LVL_W(LVL_W), .WIN_W(WIN_W), .DEG_W(DEG_W)) u_map (
        .level(aggr_level), .win_size(cur_win), .degree(cur_degree)
    );

    // Lowest-index match selection
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = NUM - 1; i >= 0; i--)
            if (hit_v[i]) begin
                sel     = IDX_W'(i);
                any_hit = 1'b1;
            end
    end

    assign accept     = miss_valid && !busy;
    assign miss_ready = !busy;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_ent
            assign upd_v[g]   = accept && any_hit && (sel == IDX_W'(g));
            assign alloc_v[g] = accept && !any_hit && (victim == IDX_W'(g));
            sst_entry #(
                .LINE_W(LINE_W), .WIN_W(WIN_W), .DEG_W(DEG_W), .TRAIN_RANGE(TRAIN_RANGE)
            ) u_ent (
                .clk(clk), .rst_n(rst_n), .miss_line(miss_line),
                .win_size(cur_win), .degree(cur_degree),
                .upd(upd_v[g]), .alloc(alloc_v[g]),
                .hit(hit_v[g]), .mon_hit(mon_v[g]),
                .pf_first(first_v[g]), .pf_up(up_v[g])
            );
        end
    endgenerate

    sst_lru #(.NUM(NUM), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(accept),
        .touch_idx(any_hit ? sel : victim), .victim(victim)
    );

    sst_pf_issuer #(.LINE_W(LINE_W), .DEG_W(DEG_W)) u_iss (
        .clk(clk), .rst_n(rst_n),
        .load(accept && any_hit && mon_v[sel]),
        .load_line(first_v[sel]), .load_up(up_v[sel]), .load_cnt(cur_degree),
        .pf_valid(pf_valid), .pf_line(pf_line), .busy(busy)
    );
endmodule

// File: rtl/sst_checker.sv
// Cycle-level properties of the stream tracker outputs, bound to the top.
module sst_checker #(
    parameter int LINE_W  = 32,
    parameter int DEG_W   = 3,
    parameter int MAX_DEG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_ready,
    input logic              pf_valid,
    input logic [LINE_W-1:0] pf_line,
    input logic [DEG_W-1:0]  degree
);
    logic [3:0] run_len;

    // Count consecutive prefetch cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (pf_valid) run_len <= (run_len == 4'hF) ? run_len : run_len + 4'd1;
        else               run_len <= '0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !pf_valid);

    p_ready_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !miss_ready);

    p_burst_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 4'(MAX_DEG));

    p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> (!pf_valid || pf_line == $past(pf_line) + LINE_W'(1)
                                || pf_line == $past(pf_line) - LINE_W'(1)));

    p_degree_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        degree == DEG_W'(1) || degree == DEG_W'(2) || degree == DEG_W'(4));
endmodule

bind sst_stream_tracker sst_checker #(.LINE_W(LINE_W), .DEG_W(DEG_W), .MAX_DEG(4)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready),
    .pf_valid(pf_valid), .pf_line(pf_line), .degree(cur_degree)
);

// File: tb/tb_sst_stream_tracker.sv
`timescale 1ns/100ps
module tb_sst_stream_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_line = '0;
    logic [2:0]  aggr_level = '0;
    logic        miss_ready, pf_valid;
    logic [31:0] pf_line;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sst_stream_tracker dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .aggr_level(aggr_level), .miss_ready(miss_ready),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    typedef struct packed {
        logic [31:0] line;
        logic [2:0]  lvl;
        logic [2:0]  cnt;
        logic [31:0] first;
        logic [31:0] last;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{32'd1000, 3'd0, 3'd0, 32'd0,    32'd0,    4'd2},  // R2 new anchor
        '{32'd1003, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 direction up
        '{32'd1005, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 agree, window 1005..1008
        '{32'd1006, 3'd0, 3'd1, 32'd1009, 32'd1009, 4'd5},  // R5
        '{32'd1009, 3'd0, 3'd1, 32'd1010, 32'd1010, 4'd6},  // R6 slid window end
        '{32'd1010, 3'd4, 3'd4, 32'd1011, 32'd1014, 4'd7},  // R7 level 4
        '{32'd960,  3'd4, 3'd4, 32'd1015, 32'd1018, 4'd6},  // R6 window grew to 64
        '{32'd1018, 3'd2, 3'd2, 32'd1019, 32'd1020, 4'd7},  // R7 level 2
        '{32'd1005, 3'd3, 3'd4, 32'd1021, 32'd1024, 4'd7},  // R7 level 3, start edge
        '{32'd1024, 3'd1, 3'd1, 32'd1025, 32'd1025, 4'd7},  // R7 level 1
        '{32'd1018, 3'd5, 3'd4, 32'd1026, 32'd1029, 4'd7},  // R7 level 5 acts as 4
        '{32'd965,  3'd0, 3'd0, 32'd0,    32'd0,    4'd6},  // R6 one below start
        '{32'd5000, 3'd0, 3'd0, 32'd0,    32'd0,    4'd2},  // R2
        '{32'd4990, 3'd0, 3'd0, 32'd0,    32'd0,    4'd8},  // R8 direction down
        '{32'd4985, 3'd0, 3'd0, 32'd0,    32'd0,    4'd8},  // R8 window 4985..4982
        '{32'd4983, 3'd0, 3'd1, 32'd4981, 32'd4981, 4'd8},  // R8
        '{32'd4981, 3'd2, 3'd2, 32'd4980, 32'd4979, 4'd8},  // R8
        '{32'd8000, 3'd0, 3'd0, 32'd0,    32'd0,    4'd2},  // R2
        '{32'd8005, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 up
        '{32'd7998, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 disagree, restart
        '{32'd8001, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 up
        '{32'd7990, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 disagree, restart
        '{32'd7985, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 down
        '{32'd7980, 3'd0, 3'd0, 32'd0,    32'd0,    4'd4},  // R4 agree
        '{32'd7979, 3'd0, 3'd1, 32'd7976, 32'd7976, 4'd4},  // R4
        '{32'd20000,3'd0, 3'd0, 32'd0,    32'd0,    4'd2},  // R2
        '{32'd20016,3'd0, 3'd0, 32'd0,    32'd0,    4'd3},  // R3 distance 16 counts
        '{32'd20010,3'd0, 3'd0, 32'd0,    32'd0,    4'd3},  // R3
        '{32'd20012,3'd0, 3'd1, 32'd20014,32'd20014,4'd3},  // R3
        '{32'd30000,3'd0, 3'd0, 32'd0,    32'd0,    4'd2},  // R2
        '{32'd30017,3'd0, 3'd0, 32'd0,    32'd0,    4'd3},  // R3 distance 17 ignored
        '{32'd29999,3'd0, 3'd0, 32'd0,    32'd0,    4'd3},  // R3 down
        '{32'd29998,3'd0, 3'd0, 32'd0,    32'd0,    4'd3},  // R3 agree
        '{32'd29996,3'd0, 3'd1, 32'd29994,32'd29994,4'd3}   // R3
    };

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; drives one miss and gathers the resulting burst
    task automatic send_miss(input logic [31:0] line, input logic [2:0] lvl,
                             output int cnt, output logic [31:0] first,
                             output logic [31:0] last, output logic rdy_after);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1'b1; miss_line = line; aggr_level = lvl;
        @(posedge clk);
        cnt = 0; first = '0; last = '0; rdy_after = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) begin
                miss_valid = 1'b0;
                rdy_after = miss_ready;
            end
            if (pf_valid) begin
                if (cnt == 0) first = pf_line;
                last = pf_line;
                cnt++;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; miss_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(pf_valid == 1'b0, 1, 32'(pf_valid), 0, "pf_valid in reset");
        check(miss_ready == 1'b1, 1, 32'(miss_ready), 1, "miss_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid == 1'b0, 1, 32'(pf_valid), 0, "pf_valid after reset");  // R1
    endtask

    initial begin
        int cnt; logic [31:0] f, l; logic r;
        do_reset();

        // Table walk
        for (int v = 0; v < NV; v++) begin
            send_miss(VEC[v].line, VEC[v].lvl, cnt, f, l, r);
            check(cnt == int'(VEC[v].cnt), int'(VEC[v].req), 32'(cnt), 32'(VEC[v].cnt), "burst count");
            if (VEC[v].cnt != 0) begin
                check(f == VEC[v].first, int'(VEC[v].req), f, VEC[v].first, "first line");
                check(l == VEC[v].last, int'(VEC[v].req), l, VEC[v].last, "last line");
                check(r == 1'b0, 10, 32'(r), 0, "ready during burst");  // R10
            end
        end

        // R9 control: 7 newer allocations keep the stream
        do_reset();
        send_miss(32'd40000, 3'd0, cnt, f, l, r);
        send_miss(32'd40003, 3'd0, cnt, f, l, r);
        send_miss(32'd40005, 3'd0, cnt, f, l, r);
        for (int k = 0; k < 7; k++) send_miss(32'd50000 + 32'(k * 100), 3'd0, cnt, f, l, r);
        send_miss(32'd40006, 3'd0, cnt, f, l, r);
        check(cnt == 1, 9, 32'(cnt), 1, "stream kept after 7 allocs");
        check(f == 32'd40009, 9, f, 32'd40009, "kept stream line");

        // R9 eviction: 8 newer allocations drop it
        do_reset();
        send_miss(32'd40000, 3'd0, cnt, f, l, r);
        send_miss(32'd40003, 3'd0, cnt, f, l, r);
        send_miss(32'd40005, 3'd0, cnt, f, l, r);
        for (int k = 0; k < 8; k++) send_miss(32'd50000 + 32'(k * 100), 3'd0, cnt, f, l, r);
        send_miss(32'd40006, 3'd0, cnt, f, l, r);
        check(cnt == 0, 9, 32'(cnt), 0, "stream evicted after 8 allocs");

        // R2 after reset: a miss inside an old window issues nothing
        do_reset();
        send_miss(32'd1006, 3'd0, cnt, f, l, r);
        check(cnt == 0, 2, 32'(cnt), 0, "fresh miss after reset");
        check(miss_ready == 1'b1, 10, 32'(miss_ready), 1, "ready when idle");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule